// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block is the feedback divider of a frequency synthesiser loop. It turns a fast input clock into a narrow phase-detector pulse once every N input cycles. N comes from a 17-bit ratio word. The upper 13 bits set a main count M and the lower 4 bits set a swallow count A, so N = 16·M + A. Internally a 16/17 dual-modulus stage divides by 17 while the swallow counter is still nonzero. It divides by 16 for the rest of the M prescaler cycles in the frame.

An optional divide-by-two stage can sit in front of the dual-modulus stage, and a static enable input switches it in. With the stage in, the output spacing doubles. The ratio word is captured on a load strobe and held as a pending value. That value becomes active only when the current frame finishes, so the output never produces a shortened period. A second output toggles on every phase-detector pulse, which gives a half-rate copy for a test port.

Top module: `rf_swallow_div`

## Requirements
- R1: While rst_ni is low, pd_o and pd_half_o are 0. After reset the active ratio is 256, so consecutive pd_o pulses are 256 cycles apart with the half-rate stage off.
- R2: The ratio word splits as M = ratio_i[16:4] and A = ratio_i[3:0]. With div2_en_i low, consecutive pd_o pulses are 16·M + A clock cycles apart.
- R3: A nonzero A adds exactly A cycles to the frame, because the prescaler divides by 17 for A of its cycles and by 16 for the remaining M − A.
- R4: With div2_en_i high, held steady since reset, the pulse spacing is 2·(16·M + A) cycles.
- R5: A ratio captured while a frame is running does not change that frame. The frame after it uses the new ratio.
- R6: When load_i is low, changes on ratio_i have no effect on the pulse spacing.
- R7: A ratio with M below 15 is replaced by 240 (M = 15, A = 0). The spacing is then 240 cycles, or 480 cycles with the half-rate stage on.
- R8: pd_o is high for exactly one clock cycle per frame. It is never high on two consecutive cycles.
- R9: pd_half_o changes value in the same cycle that pd_o is high, and only then. It therefore reads 1 at the first pulse after reset and alternates after that.
- R10: The largest ratio, 131071, gives a spacing of 131071 cycles with the half-rate stage off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input (RF-rate) clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| div2_en_i | input | 1 | Static enable for the leading divide-by-two |
| ratio_i | input | 17 | Division ratio word {M[12:0], A[3:0]} |
| load_i | input | 1 | Captures ratio_i as the pending ratio |
| pd_o | output | 1 | One-cycle pulse at the end of each frame |
| pd_half_o | output | 1 | Toggles on each pd_o pulse |

## Verification
Any corrupted counter state shows up at the ports as a wrong spacing between pd_o pulses, within one frame (at most N or 2·N cycles). Each check therefore measures the exact cycle count between two pulses. A swallow counter stuck off the right value shifts the spacing by up to 15 cycles. A pending ratio applied too early shortens the frame that was running when the strobe arrived. The bench measures that frame too, not only the one after it. A toggle flop that misses a pulse breaks the parity of pd_half_o at the very next pulse.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;
  localparam int unsigned M_W     = 13;
  localparam int unsigned A_W     = 4;
  localparam int unsigned RATIO_W = M_W + A_W;
  localparam int unsigned MOD_LO  = 2 ** A_W;       // low modulus (16)
  localparam int unsigned MIN_M   = MOD_LO - 1;     // A must finish before M
  localparam int unsigned MIN_N   = MOD_LO * MIN_M; // 240
  localparam int unsigned MAX_N   = (2 ** RATIO_W) - 1;

  typedef struct packed {
    logic [M_W-1:0] m;
    logic [A_W-1:0] a;
  } ratio_t;
endpackage

// File: rtl/swdiv_half_stage.sv
module swdiv_half_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  logic tgl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   tgl_q <= 1'b0;
    else if (en_i) tgl_q <= ~tgl_q;
    else           tgl_q <= 1'b0;
  end

  // every cycle when bypassed, every second cycle when enabled
  assign tick_o = en_i ? tgl_q : 1'b1;
endmodule

// File: rtl/swdiv_prescaler.sv
module swdiv_prescaler
  import swdiv_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic swallow_i,
  output logic pulse_o
);
  localparam int unsigned CNT_W = A_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic             last;

  // swallow_i only changes on pulse_o, when cnt_q restarts
  assign last    = swallow_i ? (cnt_q == CNT_W'(MOD_LO)) : (cnt_q == CNT_W'(MOD_LO - 1));
  assign pulse_o = tick_i & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= last ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/swdiv_swallow_ctrl.sv
module swdiv_swallow_ctrl
  import swdiv_pkg::*;
#(
  parameter int unsigned RST_RATIO = 256
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               load_i,
  input  logic               pre_pulse_i,
  output logic               swallow_o,
  output logic               frame_end_o
);
  function automatic ratio_t clamp_ratio(logic [RATIO_W-1:0] raw);
    ratio_t r;
    r = ratio_t'(raw);
    if (r.m < M_W'(MIN_M)) begin
      r.m = M_W'(MIN_M);
      r.a = '0;
    end
    return r;
  endfunction

  localparam ratio_t RST_R = clamp_ratio(RATIO_W'(RST_RATIO));

  ratio_t         pend_q;
  logic [M_W-1:0] m_q;
  logic [A_W-1:0] a_q;

  assign swallow_o   = (a_q != '0);
  assign frame_end_o = pre_pulse_i & (m_q == M_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= RST_R;
    else if (load_i) pend_q <= clamp_ratio(ratio_i);
  end

  // m_q: prescaler cycles left in frame, a_q: modulus-17 cycles left
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_q <= RST_R.m;
      a_q <= RST_R.a;
    end else if (frame_end_o) begin
      m_q <= pend_q.m;
      a_q <= pend_q.a;
    end else if (pre_pulse_i) begin
      m_q <= m_q - 1'b1;
      if (swallow_o) a_q <= a_q - 1'b1;
    end
  end
endmodule

// File: rtl/rf_swallow_div.sv
module rf_swallow_div
  import swdiv_pkg::*;
#(
  parameter int unsigned RST_RATIO = 256
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               div2_en_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               load_i,
  output logic               pd_o,
  output logic               pd_half_o
);
  logic tick, swallow, pre_pulse, frame_end;
  logic pd_q, half_q;

  swdiv_half_stage u_half (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (div2_en_i),
    .tick_o (tick)
  );

  swdiv_prescaler u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .swallow_i (swallow),
    .pulse_o   (pre_pulse)
  );

  swdiv_swallow_ctrl #(.RST_RATIO(RST_RATIO)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ratio_i     (ratio_i),
    .load_i      (load_i),
    .pre_pulse_i (pre_pulse),
    .swallow_o   (swallow),
    .frame_end_o (frame_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_q   <= 1'b0;
      half_q <= 1'b0;
    end else begin
      pd_q   <= frame_end;
      half_q <= half_q ^ frame_end;
    end
  end

  assign pd_o      = pd_q;
  assign pd_half_o = half_q;
endmodule

// File: rtl/rf_swallow_div_chk.sv
module rf_swallow_div_chk
  import swdiv_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic pd_o,
  input logic pd_half_o
);
  localparam int unsigned GAP_W   = RATIO_W + 2;
  localparam int unsigned MAX_GAP = 2 * MAX_N;

  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       gap_q <= '0;
    else if (pd_o)                     gap_q <= '0;
    else if (gap_q != {GAP_W{1'b1}})   gap_q <= gap_q + 1'b1;
  end

  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_o |=> !pd_o);

  a_r9_half_toggles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_o |-> (pd_half_o != $past(pd_half_o)));

  a_r9_half_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_o |-> $stable(pd_half_o));

  a_r7_min_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_o |-> (gap_q >= GAP_W'(MIN_N - 1)));

  a_r10_max_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_q <= GAP_W'(MAX_GAP));
endmodule

bind rf_swallow_div rf_swallow_div_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pd_o      (pd_o),
  .pd_half_o (pd_half_o)
);

// File: tb/rf_swallow_div_tb.sv
module rf_swallow_div_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        div2_en_i = 1'b0;
  logic [16:0] ratio_i = '0;
  logic        load_i = 1'b0;
  logic        pd_o, pd_half_o;

  longint cyc = 0;
  int     n_tests = 0;
  int     n_fail = 0;
  int     cur = 256;
  int     mult = 1;
  logic   half_exp = 1'b0;

  rf_swallow_div u_dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .div2_en_i (div2_en_i),
    .ratio_i   (ratio_i),
    .load_i    (load_i),
    .pd_o      (pd_o),
    .pd_half_o (pd_half_o)
  );

  always #4 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic int exp_ratio(int r);
    if ((r >> 4) < 15) return 240;
    return r;
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R9: pd_half_o flips with every pulse
  task automatic wait_pulse(output longint t);
    do @(negedge clk_i); while (!pd_o);
    t = cyc;
    half_exp = ~half_exp;
    check("R9 half-rate parity", pd_half_o, half_exp);
  endtask

  task automatic do_reset(logic d2);
    rst_ni = 1'b0;
    div2_en_i = d2;
    repeat (4) @(negedge clk_i);
    check("R1 pd_o in reset", pd_o, 0);
    check("R1 pd_half_o in reset", pd_half_o, 0);
    rst_ni = 1'b1;
    cur = 256;
    mult = d2 ? 2 : 1;
    half_exp = 1'b0;
  endtask

  task automatic do_load(int r, string tag);
    longint ta, tb, tc;
    int e;
    wait_pulse(ta);
    repeat (3) @(negedge clk_i);
    ratio_i = 17'(r);
    load_i = 1'b1;
    @(negedge clk_i);
    load_i = 1'b0;
    ratio_i = 17'($urandom);  // R6: ignored without load
    wait_pulse(tb);
    wait_pulse(tc);
    check("R5 running frame keeps old ratio", tb - ta, longint'(cur) * mult);
    e = exp_ratio(r);
    check(tag, tc - tb, longint'(e) * mult);
    cur = e;
  endtask

  initial begin
    longint t0, t1, t2;
    int unsigned seed;
    seed = 32'd2024;
    void'($urandom(seed));

    do_reset(1'b0);
    wait_pulse(t0);
    wait_pulse(t1);
    check("R1 reset ratio spacing", t1 - t0, 256);
    @(negedge clk_i);
    check("R8 pulse one cycle wide", pd_o, 0);

    ratio_i = 17'd1000;  // R6: no load strobe
    wait_pulse(t2);
    check("R6 ratio_i ignored without load", t2 - t1, 256);

    do_load(16 * 20 + 15, "R3 swallow adds A cycles");
    do_load(16 * 37 + 1, "R3 single swallow cycle");
    do_load(100, "R7 clamp below minimum");
    do_load(0, "R7 clamp zero");
    do_load(255, "R2 smallest M with A=15");
    for (int i = 0; i < 6; i++) do_load(240 + int'($urandom % 1300), "R2 random ratio");

    do_reset(1'b1);
    wait_pulse(t0);
    wait_pulse(t1);
    check("R4 div2 reset spacing", t1 - t0, 512);
    do_load(16 * 25 + 7, "R4 div2 doubles ratio");
    do_load(50, "R7 clamp with div2");

    do_reset(1'b0);
    do_load(131071, "R10 maximum ratio");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (198000) @(posedge clk_i);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule